// File: doc/BRIEF.md
# Source-Chain DMA Tag Sequencer with Return Stack

This block decides where a source-chain DMA channel goes after each tag has been decoded. The channel offers the tag's 3-bit kind, its quadword count, the tag's address field and the address the tag was read from. On a one-cycle strobe the block registers the next memory address, the next tag address and an end-of-transfer flag. Addresses step in 16-byte quadwords. Fetching tags and moving data are left to the surrounding channel, which feeds the registered results back as the next tag's inputs.

A mode input chooses between plain chaining and chaining with subroutines. With subroutines enabled, a call kind pushes the address that follows its data onto a two-entry return stack. A return kind pops from that stack. Pushing onto a full stack ends the transfer, and so does popping from an empty one.

Top module: `chainTagSeq`

## Requirements
- R1: After reset, nextMadr, nextTadr, retSlot0, retSlot1 and stackPtr are zero and xferEnd is low.
- R2: Kind 1 (count) sets nextMadr to curTadr+16 and nextTadr to curTadr+16+qwc*16. xferEnd stays low.
- R3: Kind 2 (next) sets nextMadr to curTadr+16 and nextTadr to curMadr. xferEnd stays low.
- R4: Kinds 3 and 4 (reference, reference with stall) set nextTadr to curTadr+16 and keep nextMadr equal to curMadr. xferEnd stays low.
- R5: Kind 0 (reference and end) passes curMadr and curTadr through unchanged and raises xferEnd.
- R6: Kind 7 (end) sets nextMadr to curTadr+16, keeps nextTadr equal to curTadr and raises xferEnd.
- R7: Kind 5 (call) with stackEn high, curMadr nonzero and stackPtr below 2 does four things. It sets nextMadr to curTadr+16. It writes curTadr+16+qwc*16 into retSlot0 when stackPtr is 0, or into retSlot1 when stackPtr is 1. It increments stackPtr. It sets nextTadr to curMadr.
- R8: Kind 5 with stackEn high, curMadr nonzero and stackPtr equal to 2 sets nextMadr to curTadr+16 and keeps nextTadr equal to curTadr. The stack is left untouched and xferEnd rises.
- R9: Kind 5 with stackEn high and curMadr zero acts like kind 1 on both addresses. It does not touch the stack at any pointer value, and xferEnd stays low.
- R10: Kind 6 (return) with stackEn high sets nextMadr to curTadr+16. With stackPtr at 2 it moves retSlot1 into nextTadr. With stackPtr at 1 it moves retSlot0 into nextTadr. The popped slot is cleared to zero and stackPtr decrements.
- R11: Kind 6 with stackEn high and stackPtr at 0 sets nextMadr to curTadr+16, keeps nextTadr equal to curTadr, leaves the stack alone and raises xferEnd.
- R12: With stackEn low, kinds 5 and 6 pass curMadr and curTadr through. They leave the stack alone and keep xferEnd low.
- R13: Results appear on the clock edge that samples tagValid high. Without tagValid every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tagValid | input | 1 | One-cycle strobe: a decoded tag is present |
| tagKind | input | 3 | Tag kind code |
| tagQwc | input | QWC_W | Tag quadword count |
| stackEn | input | 1 | 1 = call/return handling enabled |
| curMadr | input | ADDR_W | Memory address register; holds the tag's address field |
| curTadr | input | ADDR_W | Address the tag was read from |
| nextMadr | output | ADDR_W | Next memory address |
| nextTadr | output | ADDR_W | Next tag address |
| retSlot0 | output | ADDR_W | Return stack entry 0 |
| retSlot1 | output | ADDR_W | Return stack entry 1 |
| stackPtr | output | 2 | Number of stacked return addresses |
| xferEnd | output | 1 | Transfer ends after this tag |

## Verification
The stack registers and pointer are outputs, so a wrong push slot, a stale popped entry or a pointer that drifts shows up on the clock edge after the offending tag. A misdecoded kind or a wrong address select shows up in nextMadr, nextTadr or xferEnd on that same edge. Some faults stay hidden until a later tag: an overflow that pushes anyway, or an underflow that moves the pointer. A later return then reads the wrong address. For that reason the bench runs full call-to-overflow and return-to-underflow chains, as well as single tags.

// File: rtl/chainTagPkg.sv
package chainTagPkg;

  typedef enum logic [2:0] {
    KIND_REFE = 3'd0,
    KIND_CNT  = 3'd1,
    KIND_NEXT = 3'd2,
    KIND_REF  = 3'd3,
    KIND_REFS = 3'd4,
    KIND_CALL = 3'd5,
    KIND_RET  = 3'd6,
    KIND_END  = 3'd7
  } tagKindE;

  typedef enum logic [2:0] {
    TADR_KEEP,
    TADR_AFTER_DATA,
    TADR_FROM_MADR,
    TADR_STEP,
    TADR_POP
  } tadrSelE;

  typedef struct packed {
    logic    madrFromTag;   // madr <= curTadr + one quadword
    tadrSelE tadrSel;
    logic    push;
    logic    pop;
    logic    endXfer;
  } seqStrobeT;

  localparam int STACK_DEPTH = 2;

endpackage

// File: rtl/chainTagCtrl.sv
module chainTagCtrl
  import chainTagPkg::*;
(
  input  logic [2:0] tagKind,
  input  logic       stackEn,
  input  logic       madrZero,
  input  logic [1:0] ptr,
  output seqStrobeT  strb
);

  always_comb begin
    strb = '{madrFromTag: 1'b0, tadrSel: TADR_KEEP, push: 1'b0, pop: 1'b0, endXfer: 1'b0};
    unique case (tagKindE'(tagKind))
      KIND_REFE: strb.endXfer = 1'b1;
      KIND_CNT: begin
        strb.madrFromTag = 1'b1;
        strb.tadrSel     = TADR_AFTER_DATA;
      end
      KIND_NEXT: begin
        strb.madrFromTag = 1'b1;
        strb.tadrSel     = TADR_FROM_MADR;
      end
      KIND_REF, KIND_REFS: strb.tadrSel = TADR_STEP;
      KIND_END: begin
        strb.madrFromTag = 1'b1;
        strb.endXfer     = 1'b1;
      end
      KIND_CALL: begin
        if (stackEn) begin
          strb.madrFromTag = 1'b1;
          if (madrZero) begin
            strb.tadrSel = TADR_AFTER_DATA;
          end else if (ptr < 2'(STACK_DEPTH)) begin
            strb.push    = 1'b1;
            strb.tadrSel = TADR_FROM_MADR;
          end else begin
            strb.endXfer = 1'b1;
          end
        end
      end
      KIND_RET: begin
        if (stackEn) begin
          strb.madrFromTag = 1'b1;
          if (ptr == 2'd1 || ptr == 2'd2) begin
            strb.pop     = 1'b1;
            strb.tadrSel = TADR_POP;
          end else begin
            strb.endXfer = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/chainTagDatapath.sv
module chainTagDatapath
  import chainTagPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int QWC_W    = 16,
  parameter int QW_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tagValid,
  input  seqStrobeT         strb,
  input  logic [QWC_W-1:0]  tagQwc,
  input  logic [ADDR_W-1:0] curMadr,
  input  logic [ADDR_W-1:0] curTadr,
  output logic              madrZero,
  output logic [1:0]        ptr,
  output logic [ADDR_W-1:0] madrQ,
  output logic [ADDR_W-1:0] tadrQ,
  output logic [ADDR_W-1:0] slot0Q,
  output logic [ADDR_W-1:0] slot1Q,
  output logic              endQ
);

  localparam logic [ADDR_W-1:0] QW_BYTES = ADDR_W'(1) << QW_SHIFT;

  logic [ADDR_W-1:0] tagNext;
  logic [ADDR_W-1:0] afterData;
  logic [ADDR_W-1:0] popVal;
  logic [ADDR_W-1:0] tadrD;
  logic [1:0]        ptrQ;

  assign madrZero  = (curMadr == '0);
  assign ptr       = ptrQ;
  assign tagNext   = curTadr + QW_BYTES;
  assign afterData = tagNext + (ADDR_W'(tagQwc) << QW_SHIFT);
  assign popVal    = (ptrQ == 2'd2) ? slot1Q : slot0Q;

  always_comb begin
    unique case (strb.tadrSel)
      TADR_AFTER_DATA: tadrD = afterData;
      TADR_FROM_MADR:  tadrD = curMadr;
      TADR_STEP:       tadrD = tagNext;
      TADR_POP:        tadrD = popVal;
      default:         tadrD = curTadr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      madrQ  <= '0;
      tadrQ  <= '0;
      slot0Q <= '0;
      slot1Q <= '0;
      ptrQ   <= '0;
      endQ   <= 1'b0;
    end else if (tagValid) begin
      madrQ <= strb.madrFromTag ? tagNext : curMadr;
      tadrQ <= tadrD;
      endQ  <= strb.endXfer;
      if (strb.push) begin
        if (ptrQ == 2'd0) slot0Q <= afterData;
        else              slot1Q <= afterData;
        ptrQ <= ptrQ + 2'd1;
      end else if (strb.pop) begin
        if (ptrQ == 2'd2) slot1Q <= '0;
        else              slot0Q <= '0;
        ptrQ <= ptrQ - 2'd1;
      end
    end
  end

endmodule

// File: rtl/chainTagSeq.sv
module chainTagSeq
  import chainTagPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int QWC_W    = 16,
  parameter int QW_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tagValid,
  input  logic [2:0]        tagKind,
  input  logic [QWC_W-1:0]  tagQwc,
  input  logic              stackEn,
  input  logic [ADDR_W-1:0] curMadr,
  input  logic [ADDR_W-1:0] curTadr,
  output logic [ADDR_W-1:0] nextMadr,
  output logic [ADDR_W-1:0] nextTadr,
  output logic [ADDR_W-1:0] retSlot0,
  output logic [ADDR_W-1:0] retSlot1,
  output logic [1:0]        stackPtr,
  output logic              xferEnd
);

  seqStrobeT strb;
  logic      madrZero;
  logic [1:0] ptr;

  chainTagCtrl u_ctrl (
    .tagKind (tagKind),
    .stackEn (stackEn),
    .madrZero(madrZero),
    .ptr     (ptr),
    .strb    (strb)
  );

  chainTagDatapath #(
    .ADDR_W  (ADDR_W),
    .QWC_W   (QWC_W),
    .QW_SHIFT(QW_SHIFT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tagValid(tagValid),
    .strb    (strb),
    .tagQwc  (tagQwc),
    .curMadr (curMadr),
    .curTadr (curTadr),
    .madrZero(madrZero),
    .ptr     (ptr),
    .madrQ   (nextMadr),
    .tadrQ   (nextTadr),
    .slot0Q  (retSlot0),
    .slot1Q  (retSlot1),
    .endQ    (xferEnd)
  );

  assign stackPtr = ptr;

endmodule

// File: rtl/chainTagSeqChk.sv
module chainTagSeqChk #(
  parameter int ADDR_W = 32,
  parameter int QWC_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              tagValid,
  input logic [2:0]        tagKind,
  input logic [QWC_W-1:0]  tagQwc,
  input logic              stackEn,
  input logic [ADDR_W-1:0] curMadr,
  input logic [ADDR_W-1:0] curTadr,
  input logic [ADDR_W-1:0] nextMadr,
  input logic [ADDR_W-1:0] nextTadr,
  input logic [ADDR_W-1:0] retSlot0,
  input logic [ADDR_W-1:0] retSlot1,
  input logic [1:0]        stackPtr,
  input logic              xferEnd
);

  logic live;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) live <= 1'b0;
    else       live <= 1'b1;

  logic callGo, callFull, retEmpty, stackOff;
  assign callGo   = live && tagValid && stackEn && tagKind == 3'd5 && curMadr != '0 && stackPtr < 2'd2;
  assign callFull = live && tagValid && stackEn && tagKind == 3'd5 && curMadr != '0 && stackPtr == 2'd2;
  assign retEmpty = live && tagValid && stackEn && tagKind == 3'd6 && stackPtr == 2'd0;
  assign stackOff = live && tagValid && !stackEn && (tagKind == 3'd5 || tagKind == 3'd6);

  // R7, R8, R10
  p_ptr_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    stackPtr != 2'd3);

  p_push_r7: assert property (@(posedge clk) disable iff (!rstN)
    callGo |=> stackPtr == $past(stackPtr) + 2'd1 && nextTadr == $past(curMadr) && !xferEnd);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    callFull |=> xferEnd && stackPtr == 2'd2 && nextTadr == $past(curTadr));

  p_underflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    retEmpty |=> xferEnd && stackPtr == 2'd0 && nextTadr == $past(curTadr));

  p_stack_off_r12: assert property (@(posedge clk) disable iff (!rstN)
    stackOff |=> !xferEnd && $stable(stackPtr) && nextMadr == $past(curMadr)
                 && nextTadr == $past(curTadr));

  p_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (live && tagValid && tagKind == 3'd7) |=> xferEnd && nextTadr == $past(curTadr));

  p_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (live && !tagValid) |=> $stable(nextMadr) && $stable(nextTadr) && $stable(stackPtr)
                            && $stable(retSlot0) && $stable(retSlot1) && $stable(xferEnd));

endmodule

bind chainTagSeq chainTagSeqChk #(.ADDR_W(ADDR_W), .QWC_W(QWC_W)) u_chk (
  .clk(clk), .rstN(rstN), .tagValid(tagValid), .tagKind(tagKind), .tagQwc(tagQwc),
  .stackEn(stackEn), .curMadr(curMadr), .curTadr(curTadr), .nextMadr(nextMadr),
  .nextTadr(nextTadr), .retSlot0(retSlot0), .retSlot1(retSlot1), .stackPtr(stackPtr),
  .xferEnd(xferEnd)
);

// File: tb/chainTagSeq_tb.sv
`timescale 1ns/1ps
module chainTagSeq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tagValid = 1'b0;
  logic [2:0]  tagKind = '0;
  logic [15:0] tagQwc = '0;
  logic        stackEn = 1'b0;
  logic [31:0] curMadr = '0;
  logic [31:0] curTadr = '0;
  logic [31:0] nextMadr, nextTadr, retSlot0, retSlot1;
  logic [1:0]  stackPtr;
  logic        xferEnd;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  logic [31:0] eMadr, eTadr, eS0, eS1;
  logic [1:0]  ePtr;
  logic        eEnd;

  always #2 clk = ~clk;

  chainTagSeq u_dut (
    .clk(clk), .rstN(rstN), .tagValid(tagValid), .tagKind(tagKind), .tagQwc(tagQwc),
    .stackEn(stackEn), .curMadr(curMadr), .curTadr(curTadr), .nextMadr(nextMadr),
    .nextTadr(nextTadr), .retSlot0(retSlot0), .retSlot1(retSlot1), .stackPtr(stackPtr),
    .xferEnd(xferEnd)
  );

  function automatic string reqOf(input logic [2:0] k, input logic en,
                                  input logic [31:0] m, input logic [1:0] p);
    case (k)
      3'd0: return "R5";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      3'd7: return "R6";
      3'd5: return !en ? "R12" : (m == 0) ? "R9" : (p == 2) ? "R8" : "R7";
      default: return !en ? "R12" : (p == 0) ? "R11" : "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chkAll(input string req);
    chk(req, "nextMadr", nextMadr, eMadr);
    chk(req, "nextTadr", nextTadr, eTadr);
    chk(req, "retSlot0", retSlot0, eS0);
    chk(req, "retSlot1", retSlot1, eS1);
    chk(req, "stackPtr", 32'(stackPtr), 32'(ePtr));
    chk(req, "xferEnd", 32'(xferEnd), 32'(eEnd));
  endtask

  // expected result computed from the requirement text
  task automatic model(input logic [2:0] k, input logic [15:0] q, input logic en,
                       input logic [31:0] m, input logic [31:0] t);
    logic [31:0] step, after;
    step  = t + 32'd16;
    after = step + {12'd0, q, 4'd0};
    eMadr = m; eTadr = t; eEnd = 1'b0;
    case (k)
      3'd0: eEnd = 1'b1;
      3'd1: begin eMadr = step; eTadr = after; end
      3'd2: begin eMadr = step; eTadr = m; end
      3'd3, 3'd4: eTadr = step;
      3'd7: begin eMadr = step; eEnd = 1'b1; end
      3'd5: if (en) begin
        eMadr = step;
        if (m == 0) eTadr = after;
        else if (ePtr == 2'd0) begin eS0 = after; ePtr = 2'd1; eTadr = m; end
        else if (ePtr == 2'd1) begin eS1 = after; ePtr = 2'd2; eTadr = m; end
        else eEnd = 1'b1;
      end
      default: if (en) begin
        eMadr = step;
        if (ePtr == 2'd2) begin eTadr = eS1; eS1 = 0; ePtr = 2'd1; end
        else if (ePtr == 2'd1) begin eTadr = eS0; eS0 = 0; ePtr = 2'd0; end
        else eEnd = 1'b1;
      end
    endcase
  endtask

  task automatic runTag(input logic [2:0] k, input logic [15:0] q, input logic en,
                        input logic [31:0] m, input logic [31:0] t);
    string req;
    req = reqOf(k, en, m, ePtr);
    @(negedge clk);
    tagKind = k; tagQwc = q; stackEn = en; curMadr = m; curTadr = t; tagValid = 1'b1;
    model(k, q, en, m, t);
    @(negedge clk);
    tagValid = 1'b0;
    chkAll(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] mPat [4];
    logic [31:0] tPat [4];
    logic [15:0] qPat [4];
    mPat = '{32'h0, 32'h0000_1000, 32'hFFFF_FFF0, 32'h0000_0020};
    tPat = '{32'h0000_0100, 32'hFFFF_FFF0, 32'h0, 32'h1234_5670};
    qPat = '{16'h0, 16'h1, 16'hFFFF, 16'h7};
    eMadr = 0; eTadr = 0; eS0 = 0; eS1 = 0; ePtr = 0; eEnd = 0;

    repeat (3) @(negedge clk);
    chkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    chkAll("R1");

    // sweep every kind, both modes, several address/count patterns
    for (int k = 0; k < 8; k++)
      for (int en = 0; en < 2; en++)
        for (int p = 0; p < 4; p++)
          for (int r = 0; r < 4; r++)
            runTag(3'(k), qPat[(p + r) % 4], 1'(en), mPat[p], tPat[r]);

    // drain the stack, then walk push to overflow and pop to underflow
    for (int i = 0; i < 3; i++) runTag(3'd6, 16'd0, 1'b1, 32'h0, 32'h40);
    runTag(3'd5, 16'd3, 1'b1, 32'h0000_0A00, 32'h0000_0100);   // R7 slot 0
    runTag(3'd5, 16'd0, 1'b1, 32'h0000_0B00, 32'h0000_0A10);   // R7 slot 1
    runTag(3'd5, 16'd5, 1'b1, 32'h0, 32'h0000_0B00);           // R9 full, no push
    runTag(3'd5, 16'd2, 1'b1, 32'h0000_0C00, 32'h0000_0B70);   // R8 overflow
    runTag(3'd6, 16'd1, 1'b0, 32'h0000_0C00, 32'h0000_0B70);   // R12 ignored
    runTag(3'd6, 16'd1, 1'b1, 32'h0000_0C00, 32'h0000_0C00);   // R10 pop slot 1
    runTag(3'd6, 16'd1, 1'b1, 32'h0000_0C00, 32'h0000_0B10);   // R10 pop slot 0
    runTag(3'd6, 16'd1, 1'b1, 32'h0000_0C00, 32'h0000_0140);   // R11 underflow

    // R13: idle cycles with changing inputs leave outputs alone
    @(negedge clk);
    tagKind = 3'd1; curMadr = 32'hDEAD_0000; curTadr = 32'h5550; stackEn = 1'b1;
    repeat (3) @(negedge clk);
    chkAll("R13");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule